// File: doc/BRIEF.md
# Dual FIFO with Coded Watermark Flags

This block holds two independent byte queues for a serial link controller: one that software fills with bytes for the transmitter, and one that the receiver fills for software to drain. Each queue is 128 bytes deep, works first-in first-out, and shows full and empty. Its head byte is always visible on the read data output.

Software picks one watermark level for each queue by writing a 3-bit code into a control register. The code selects a threshold from a fixed table. A transmit-low flag warns that the transmit queue is running dry, and a receive-high flag warns that the receive queue is close to full. Both flags follow the fill level continuously and are never latched. Each flag can reach a shared interrupt line through its own enable bit.

A push into a full queue and a pop from an empty queue are dropped. Each such event is recorded in a sticky error bit that software clears by writing 1 to it.

Top module: `fwm_pair`

## Requirements
- R1: Register address 0 is the control register. Bits 2:0 hold the receive watermark code and bits 5:3 hold the transmit watermark code. Bits 7:6 always read 0, whatever was written to them. The register is 0 after reset.
- R2: A watermark code selects a threshold in bytes. Code 0 selects 4. Codes 1 to 7 select 16 times the code, so code 7 selects 112.
- R3: `tx_low` is 1 when the transmit level is strictly below the transmit threshold. The flag is registered, so it reflects the level and control value from the previous cycle.
- R4: `rx_high` is 1 when the receive level is strictly above the receive threshold, with the same one-cycle lag as R3.
- R5: A level exactly equal to its threshold asserts neither flag.
- R6: Register address 1 holds the interrupt enables: bit 0 for `tx_low` and bit 1 for `rx_high`. `irq` is (`tx_low` AND bit 0) OR (`rx_high` AND bit 1).
- R7: Each queue holds up to 128 bytes in order. `*_full` is 1 at 128 bytes and `*_empty` is 1 at 0 bytes. `*_q` shows the oldest byte.
- R8: A push into a full queue and a pop from an empty queue leave the queue unchanged. They set sticky bits at register address 2: bit 0 transmit overflow, bit 1 transmit underflow, bit 2 receive overflow, bit 3 receive underflow.
- R9: Writing 1 to a bit of register address 2 clears that bit. If an error event happens in the same cycle as the clear, the bit stays set.
- R10: Register address 3 reads the flags: bit 0 is `tx_low` and bit 1 is `rx_high`. Writes to this address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop the transmit queue head |
| tx_q | output | 8 | Transmit queue head byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Push `rx_data` into the receive queue |
| rx_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop the receive queue head |
| rx_q | output | 8 | Receive queue head byte |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_low | output | 1 | Transmit level below its watermark |
| rx_high | output | 1 | Receive level above its watermark |
| irq | output | 1 | Shared interrupt, active high |

## Verification
For every code, the bench walks both queues from empty to full and back. This puts each threshold one byte below, at, and one byte above its level.
- A comparator written with `<=` or `>=` shows up as a flag at the exact threshold.
- A mis-coded table entry moves the flag's edge to the wrong byte.
- A flag that is not registered changes one cycle early.

It also pushes one byte past full and pops one byte past empty. A queue that wraps or underflows would corrupt the head byte or the full and empty flags, and a missing sticky bit would read back as 0. Random traffic then mixes simultaneous push and pop with clears that land in the same cycle as new errors. A design that lets the clear win would drop an event.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_IEN  = 2'd1,
        REG_ERR  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic [2:0] tx_code;
        logic [2:0] rx_code;
    } ctrl_t;

    typedef struct packed {
        logic rx_unf;
        logic rx_ovf;
        logic tx_unf;
        logic tx_ovf;
    } err_t;

    localparam int THR_W = 8;

    // Coded watermark: code 0 is the small level, others step by 16 bytes
    function automatic logic [THR_W-1:0] wm_bytes(input logic [2:0] code);
        if (code == 3'd0)
            return 8'd4;
        return {1'b0, code, 4'b0000};
    endfunction

endpackage

// File: rtl/fwm_fifo.sv
module fwm_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              empty,
    output logic [AW:0]       level,
    output logic              ovf_evt,
    output logic              unf_evt
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0]       wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign level   = wr_ptr - rd_ptr;
    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (wr_ptr == rd_ptr);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf_evt = push && full;
    assign unf_evt = pop && empty;
    assign rdata   = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/fwm_wm_flag.sv
module fwm_wm_flag
    import fwm_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter bit ABOVE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [2:0]       code,
    output logic             flag
);
    logic [LVL_W-1:0] thr;
    logic             hit;

    assign thr = LVL_W'(wm_bytes(code));

    generate
        if (ABOVE) begin : g_above
            assign hit = (level > thr);
        end else begin : g_below
            assign hit = (level < thr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= hit;
    end
endmodule

// File: rtl/fwm_regs.sv
module fwm_regs
    import fwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  err_t       evt,
    input  logic       tx_low,
    input  logic       rx_high,
    output ctrl_t      ctrl,
    output logic [1:0] ien,
    output logic [7:0] rdata
);
    err_t err, clr;

    assign clr = (wr && addr == REG_ERR) ? err_t'(wdata[3:0]) : err_t'(4'b0000);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ien  <= '0;
            err  <= '0;
        end else begin
            if (wr && addr == REG_CTRL)
                ctrl <= '{rsvd: 2'b00, tx_code: wdata[5:3], rx_code: wdata[2:0]};
            if (wr && addr == REG_IEN)
                ien <= wdata[1:0];
            err <= (err & ~clr) | evt;
        end
    end

    always_comb begin
        case (addr)
            REG_CTRL: rdata = ctrl;
            REG_IEN:  rdata = {6'b0, ien};
            REG_ERR:  rdata = {4'b0, err};
            default:  rdata = {6'b0, rx_high, tx_low};
        endcase
    end
endmodule

// File: rtl/fwm_pair.sv
module fwm_pair
    import fwm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_q,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_q,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              tx_low,
    output logic              rx_high,
    output logic              irq
);
    logic [LVL_W-1:0] tx_level, rx_level;
    err_t             evt;
    ctrl_t            ctrl;
    logic [1:0]       ien;

    fwm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tx_fifo (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_q), .full(tx_full), .empty(tx_empty), .level(tx_level),
        .ovf_evt(evt.tx_ovf), .unf_evt(evt.tx_unf)
    );

    fwm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_fifo (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_data), .pop(rx_pop),
        .rdata(rx_q), .full(rx_full), .empty(rx_empty), .level(rx_level),
        .ovf_evt(evt.rx_ovf), .unf_evt(evt.rx_unf)
    );

    fwm_wm_flag #(.LVL_W(LVL_W), .ABOVE(1'b0)) i_tx_flag (
        .clk(clk), .rst(rst), .level(tx_level), .code(ctrl.tx_code), .flag(tx_low)
    );

    fwm_wm_flag #(.LVL_W(LVL_W), .ABOVE(1'b1)) i_rx_flag (
        .clk(clk), .rst(rst), .level(rx_level), .code(ctrl.rx_code), .flag(rx_high)
    );

    fwm_regs i_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .evt(evt), .tx_low(tx_low), .rx_high(rx_high),
        .ctrl(ctrl), .ien(ien), .rdata(reg_rdata)
    );

    assign irq = (tx_low & ien[0]) | (rx_high & ien[1]);
endmodule

// File: rtl/fwm_pair_chk.sv
module fwm_pair_chk (
    input logic clk,
    input logic rst,
    input logic tx_push,
    input logic tx_pop,
    input logic rx_push,
    input logic rx_pop,
    input logic tx_full,
    input logic tx_empty,
    input logic rx_full,
    input logic rx_empty,
    input logic tx_low,
    input logic rx_high,
    input logic irq
);
    p_full_empty_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

    p_irq_source_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (tx_low || rx_high));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_full && tx_push && !tx_pop) |=> tx_full);

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && rx_pop && !rx_push) |=> rx_empty);

    p_empty_is_low_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_empty) && !$past(rst)) |-> tx_low);

    p_full_is_high_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_full) && !$past(rst)) |-> rx_high);
endmodule

bind fwm_pair fwm_pair_chk i_fwm_pair_chk (
    .clk(clk), .rst(rst),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_low(tx_low), .rx_high(rx_high), .irq(irq)
);

// File: tb/test_fwm_pair.sv
module test_fwm_pair;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = 8'd0, rx_data = 8'd0;
    logic [7:0] tx_q, rx_q;
    logic       tx_full, tx_empty, rx_full, rx_empty, tx_low, rx_high, irq;

    fwm_pair i_fwm_pair (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_q(tx_q),
        .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop), .rx_q(rx_q),
        .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_low(tx_low), .rx_high(rx_high), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] txm[$];
    logic [7:0] rxm[$];
    logic [2:0] m_txc = 3'd0, m_rxc = 3'd0;
    logic [1:0] m_en = 2'd0;
    logic [3:0] m_err = 4'd0;
    logic       m_low = 1'b0, m_high = 1'b0;
    bit         tx_eq = 1'b0, rx_eq = 1'b0;

    function automatic int ref_thr(input logic [2:0] c);
        case (c)
            3'd0: return 4;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 48;
            3'd4: return 64;
            3'd5: return 80;
            3'd6: return 96;
            default: return 112;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [3:0] evt, clr;
        bit nl, nh;
        if (rst) begin
            txm.delete(); rxm.delete();
            m_txc = 0; m_rxc = 0; m_en = 0; m_err = 0;
            m_low = 0; m_high = 0; tx_eq = 0; rx_eq = 0;
            return;
        end
        nl = txm.size() < ref_thr(m_txc);
        nh = rxm.size() > ref_thr(m_rxc);
        tx_eq = txm.size() == ref_thr(m_txc);
        rx_eq = rxm.size() == ref_thr(m_rxc);
        evt = {rx_pop && rxm.size() == 0, rx_push && rxm.size() == 128,
               tx_pop && txm.size() == 0, tx_push && txm.size() == 128};
        clr = 4'd0;
        if (reg_wr) begin
            case (reg_addr)
                2'd0: begin m_rxc = reg_wdata[2:0]; m_txc = reg_wdata[5:3]; end
                2'd1: m_en = reg_wdata[1:0];
                2'd2: clr = reg_wdata[3:0];
                default: ;
            endcase
        end
        m_err = (m_err & ~clr) | evt;
        if (tx_pop && txm.size() != 0) void'(txm.pop_front());
        if (tx_push && !evt[0]) txm.push_back(tx_data);
        if (rx_pop && rxm.size() != 0) void'(rxm.pop_front());
        if (rx_push && !evt[2]) rxm.push_back(rx_data);
        m_low = nl;
        m_high = nh;
    endtask

    task automatic compare();
        int exp_rd;
        string tag;
        chk("R7 tx_empty", tx_empty, txm.size() == 0);
        chk("R7 tx_full", tx_full, txm.size() == 128);
        chk("R7 rx_empty", rx_empty, rxm.size() == 0);
        chk("R7 rx_full", rx_full, rxm.size() == 128);
        if (txm.size() != 0) chk("R7 tx head order", tx_q, txm[0]);
        if (rxm.size() != 0) chk("R7 rx head order", rx_q, rxm[0]);
        chk(tx_eq ? "R5 tx_low at equal level" : "R3 R2 tx_low", tx_low, m_low);
        chk(rx_eq ? "R5 rx_high at equal level" : "R4 R2 rx_high", rx_high, m_high);
        chk("R6 irq", irq, (m_low & m_en[0]) | (m_high & m_en[1]));
        case (reg_addr)
            2'd0: begin exp_rd = {2'b00, m_txc, m_rxc}; tag = "R1 control read"; end
            2'd1: begin exp_rd = m_en; tag = "R6 enable read"; end
            2'd2: begin exp_rd = m_err; tag = "R8 R9 error read"; end
            default: begin exp_rd = {m_high, m_low}; tag = "R10 status read"; end
        endcase
        chk(tag, reg_rdata, exp_rd);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        reg_wr = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] seq = 8'd0;
        @(negedge clk);
        rst = 1;
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        // reset values of all registers (R1, R6, R8, R10)
        for (int a = 0; a < 4; a++) rd(2'(a));
        // reserved bits read 0 (R1)
        wr(2'd0, 8'hFF);
        rd(2'd0);
        // writes to status address ignored (R10)
        wr(2'd3, 8'hFF);
        rd(2'd3);
        wr(2'd0, 8'h00);
        // every code: sweep both queues through full and empty (R2..R5, R7, R8)
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, {2'b00, 3'(c), 3'(c)});
            wr(2'd1, 8'h03);
            reg_addr = 2'd3;
            for (int k = 0; k < 129; k++) begin
                tx_push = 1; rx_push = 1;
                tx_data = seq; rx_data = seq ^ 8'hA5;
                seq = seq + 1;
                tick();
            end
            rd(2'd2);
            for (int k = 0; k < 129; k++) begin
                tx_pop = 1; rx_pop = 1;
                reg_addr = 2'd3;
                tick();
            end
            rd(2'd2);
            wr(2'd2, 8'h05);   // partial clear (R9)
            rd(2'd2);
            wr(2'd2, 8'h0F);
            rd(2'd2);
        end
        // interrupt enables one at a time (R6)
        wr(2'd1, 8'h01); rd(2'd1);
        wr(2'd1, 8'h02); rd(2'd1);
        // random traffic, including clears colliding with new events (R9)
        for (int i = 0; i < 5000; i++) begin
            tx_push = ($urandom_range(0, 99) < 55);
            tx_pop  = ($urandom_range(0, 99) < 45);
            rx_push = ($urandom_range(0, 99) < 45);
            rx_pop  = ($urandom_range(0, 99) < 55);
            tx_data = 8'($urandom);
            rx_data = 8'($urandom);
            reg_addr = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 19) == 0) begin
                reg_wr = 1;
                reg_wdata = 8'($urandom);
            end
            tick();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule